// File: doc/BRIEF.md
# Binarized Neuron XNOR-Popcount Unit

This block evaluates one neuron of a fully connected binarized layer. Every synapse weight and every input activation is a single bit, where logic 1 stands for +1 and logic 0 stands for -1. Multiplying a weight by an input therefore becomes a one-bit XNOR. The count of ones over the whole fan-in, minus a learned per-neuron threshold, decides the output: the neuron fires (+1) when the difference is zero or positive.

The weights sit in an internal register file of `NUM_WORDS` words of `WORD_W` bits. By default this is 32 words of 32 bits, a fan-in of 1024. A `start` pulse given while idle clears the accumulator and opens a valid/ready stream. The stream takes exactly `NUM_WORDS` activation words, and word k is paired with stored weight word k. One cycle after the last word is accepted, the result appears for one cycle together with the raw ones count. The threshold is a signed register loaded through a configuration port while the unit is idle.

For tests of error tolerance, an injection strobe XORs a bit mask into one stored weight word, which models a faulty write. Every later evaluation then uses the corrupted weight.

Top module: `bnn_neuron_unit`

## Requirements
- R1: After reset, `out_valid` and `act_ready` are 0, every stored weight bit is 0 and the threshold is 0, so an all-zero activation stream then gives a count equal to the fan-in and an output of 1.
- R2: Logic 1 encodes +1 and logic 0 encodes -1; a synapse contributes one to the count exactly when its weight bit equals its activation bit (XNOR).
- R3: `out_popcnt` equals the total of matching bit pairs over all `NUM_WORDS` words, where the k-th accepted activation word pairs with weight word index k.
- R4: `out_act` is 1 when `out_popcnt` minus the signed threshold is zero or positive, and 0 when it is negative.
- R5: `out_valid` is high for exactly one cycle, in the cycle after the last word is accepted, and `act_ready` is low in that cycle.
- R6: A `start` pulse while a run is in progress has no effect on that run.
- R7: A threshold write (`cfg_we`) while a run is in progress is ignored; threshold writes take effect only while idle.
- R8: An injection (`inj_en`) XORs `inj_mask` into weight word `inj_idx`; the change persists and is used by every later run.
- R9: While idle, `act_ready` is 0 and activation words offered on `act_valid` are not counted.
- R10: Each accepted `start` clears the accumulator, so back-to-back runs on identical data give identical results.
- R11: When a weight write and an injection target the same word in one cycle, the stored word becomes `wt_data ^ inj_mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run when idle |
| act_valid | input | 1 | Activation word offered |
| act_data | input | WORD_W | Packed activation bits, 1 = +1 |
| act_ready | output | 1 | Unit accepts an activation word |
| wt_we | input | 1 | Weight word write strobe |
| wt_idx | input | IDX_W | Weight word index to write |
| wt_data | input | WORD_W | Weight word, 1 = +1 |
| inj_en | input | 1 | Error-injection strobe |
| inj_idx | input | IDX_W | Weight word index to corrupt |
| inj_mask | input | WORD_W | Bits to flip in that word |
| cfg_we | input | 1 | Threshold write strobe |
| cfg_thr | input | THR_W | Signed threshold value |
| out_valid | output | 1 | One-cycle result strobe |
| out_act | output | 1 | Output activation, 1 = +1 |
| out_popcnt | output | CNT_W | Ones count over the fan-in |

## Verification
The assertions assume that `start`, `cfg_we`, `wt_we` and `inj_en` are driven to known levels from reset onward. They also assume that the activation stream respects `act_ready`, so a word counts as delivered only in a cycle where both handshake signals are high. The stimulus changes every input half a cycle away from the sampling edge. It keeps `act_valid` asserted across each run, with a single exception: the idle-phase test deliberately offers words while `act_ready` is low. The stimulus also issues mid-run `start` and threshold writes only on cycles that are not the final accepted word.

// File: rtl/bnn_pkg.sv
package bnn_pkg;
   typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_RUN = 1'b1} run_state_t;

   function automatic int unsigned bits_for(input int unsigned max_val);
      return $clog2(max_val + 1);
   endfunction
endpackage

// File: rtl/bnn_weight_rf.sv
module bnn_weight_rf #(
   parameter int unsigned WORD_W    = 32,
   parameter int unsigned NUM_WORDS = 32,
   parameter int unsigned IDX_W     = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              inj_en,
   input  logic [IDX_W-1:0]  inj_idx,
   input  logic [WORD_W-1:0] inj_mask,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [WORD_W-1:0] rd_data
);
   logic [WORD_W-1:0] words [NUM_WORDS];

   for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
      logic [WORD_W-1:0] word_q;
      logic [WORD_W-1:0] word_d;
      logic              wr_hit;
      logic              inj_hit;

      assign wr_hit  = wr_en  && (wr_idx  == IDX_W'(i));
      assign inj_hit = inj_en && (inj_idx == IDX_W'(i));

      // write first, then the injected flip lands on top of it
      always_comb begin
         word_d = word_q;
         if (wr_hit)  word_d = wr_data;
         if (inj_hit) word_d = word_d ^ inj_mask;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) word_q <= '0;
         else        word_q <= word_d;
      end

      assign words[i] = word_q;

      // R8: an injection alone flips exactly the masked bits
      a_r8_inject_flip: assert property (@(posedge clk) disable iff (!rst_n)
         (inj_hit && !wr_hit) |=> (word_q == ($past(word_q) ^ $past(inj_mask))));

      // R11: write and injection on the same word combine
      a_r11_write_inject: assert property (@(posedge clk) disable iff (!rst_n)
         (inj_hit && wr_hit) |=> (word_q == ($past(wr_data) ^ $past(inj_mask))));
   end

   assign rd_data = words[rd_idx];
endmodule

// File: rtl/bnn_xnor_popcnt.sv
module bnn_xnor_popcnt #(
   parameter int unsigned WORD_W   = 32,
   parameter int unsigned PC_W     = 6,
   parameter bit          USE_TREE = 1'b1
) (
   input  logic [WORD_W-1:0] act,
   input  logic [WORD_W-1:0] wt,
   output logic [PC_W-1:0]   pc
);
   localparam int unsigned LVLS = $clog2(WORD_W);

   logic [WORD_W-1:0] match;
   assign match = ~(act ^ wt);

   if (USE_TREE) begin : g_tree
      if ((1 << LVLS) != WORD_W) begin : g_bad_width
         $error("bnn_xnor_popcnt: tree variant needs a power-of-two WORD_W");
      end
      for (genvar l = 0; l <= LVLS; l++) begin : g_lvl
         localparam int unsigned N = WORD_W >> l;
         logic [N*PC_W-1:0] v;
         if (l == 0) begin : g_leaf
            for (genvar j = 0; j < N; j++) begin : g_j
               assign v[j*PC_W +: PC_W] = PC_W'(match[j]);
            end
         end else begin : g_add
            for (genvar j = 0; j < N; j++) begin : g_j
               assign v[j*PC_W +: PC_W] = g_lvl[l-1].v[(2*j)*PC_W +: PC_W]
                                        + g_lvl[l-1].v[(2*j+1)*PC_W +: PC_W];
            end
         end
      end
      assign pc = g_lvl[LVLS].v[PC_W-1:0];
   end else begin : g_chain
      always_comb begin
         pc = '0;
         for (int i = 0; i < WORD_W; i++) pc = pc + PC_W'(match[i]);
      end
   end

   // R3: a single word never contributes more than its width
   always_comb begin
      a_r3_word_bound: assert (pc <= PC_W'(WORD_W));
   end
endmodule

// File: rtl/bnn_seq_ctrl.sv
module bnn_seq_ctrl
   import bnn_pkg::*;
#(
   parameter int unsigned WORD_W    = 32,
   parameter int unsigned NUM_WORDS = 32,
   parameter int unsigned IDX_W     = 5,
   parameter int unsigned PC_W      = 6,
   parameter int unsigned CNT_W     = 11,
   parameter int unsigned THR_W     = 12,
   parameter int unsigned DIFF_W    = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              act_valid,
   output logic              act_ready,
   input  logic [PC_W-1:0]   word_pc,
   input  logic              cfg_we,
   input  logic [THR_W-1:0]  cfg_thr,
   output logic [IDX_W-1:0]  word_idx,
   output logic              out_valid,
   output logic              out_act,
   output logic [CNT_W-1:0]  out_popcnt
);
   localparam int unsigned FAN_IN = WORD_W * NUM_WORDS;

   run_state_t              state_q;
   logic [IDX_W-1:0]        idx_q;
   logic [CNT_W-1:0]        acc_q;
   logic [THR_W-1:0]        thr_q;
   logic                    running;
   logic                    fire;
   logic                    last_word;
   logic [CNT_W-1:0]        acc_sum;
   logic signed [DIFF_W-1:0] diff;

   assign running   = (state_q == ST_RUN);
   assign act_ready = running;
   assign fire      = running && act_valid;
   assign last_word = (idx_q == IDX_W'(NUM_WORDS - 1));
   assign acc_sum   = acc_q + CNT_W'(word_pc);
   assign diff      = $signed({{(DIFF_W-CNT_W){1'b0}}, acc_sum})
                    - $signed({{(DIFF_W-THR_W){thr_q[THR_W-1]}}, thr_q});
   assign word_idx  = idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         idx_q      <= '0;
         acc_q      <= '0;
         out_valid  <= 1'b0;
         out_act    <= 1'b0;
         out_popcnt <= '0;
      end else begin
         out_valid <= 1'b0;
         if (!running) begin
            if (start) begin
               state_q <= ST_RUN;
               idx_q   <= '0;
               acc_q   <= '0;
            end
         end else if (fire) begin
            acc_q <= acc_sum;
            idx_q <= idx_q + 1'b1;
            if (last_word) begin
               state_q    <= ST_IDLE;
               out_valid  <= 1'b1;
               out_act    <= ~diff[DIFF_W-1];
               out_popcnt <= acc_sum;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 thr_q <= '0;
      else if (cfg_we && !running) thr_q <= cfg_thr;
   end

   // R5: the result strobe lasts a single cycle
   a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   // R5: no further word is taken while the result is shown
   a_r5_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !act_ready);

   // R6: a start during a run neither ends nor rewinds it
   a_r6_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (running && start && !act_valid) |=> (running && $stable(idx_q)));

   // R7: the threshold cannot move during a run
   a_r7_thr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (running && cfg_we) |=> $stable(thr_q));

   // R4: a difference of exactly zero fires the neuron
   a_r4_zero_fires: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && ($signed({{(DIFF_W-CNT_W){1'b0}}, out_popcnt})
                     == $signed({{(DIFF_W-THR_W){thr_q[THR_W-1]}}, thr_q}))) |-> out_act);

   // R3: the total never exceeds the fan-in
   a_r3_total_bound: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_popcnt <= CNT_W'(FAN_IN)));
endmodule

// File: rtl/bnn_neuron_unit.sv
module bnn_neuron_unit
   import bnn_pkg::*;
#(
   parameter int unsigned WORD_W    = 32,
   parameter int unsigned NUM_WORDS = 32,
   parameter int unsigned THR_W     = 12,
   parameter bit          USE_TREE  = 1'b1,
   localparam int unsigned IDX_W    = $clog2(NUM_WORDS),
   localparam int unsigned CNT_W    = bits_for(WORD_W * NUM_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              act_valid,
   input  logic [WORD_W-1:0] act_data,
   output logic              act_ready,
   input  logic              wt_we,
   input  logic [IDX_W-1:0]  wt_idx,
   input  logic [WORD_W-1:0] wt_data,
   input  logic              inj_en,
   input  logic [IDX_W-1:0]  inj_idx,
   input  logic [WORD_W-1:0] inj_mask,
   input  logic              cfg_we,
   input  logic [THR_W-1:0]  cfg_thr,
   output logic              out_valid,
   output logic              out_act,
   output logic [CNT_W-1:0]  out_popcnt
);
   localparam int unsigned PC_W   = bits_for(WORD_W);
   localparam int unsigned DIFF_W = ((CNT_W + 1 > THR_W) ? CNT_W + 1 : THR_W) + 1;

   if (NUM_WORDS < 2) begin : g_bad_depth
      $error("bnn_neuron_unit: NUM_WORDS must be at least 2");
   end
   if (WORD_W < 2) begin : g_bad_word
      $error("bnn_neuron_unit: WORD_W must be at least 2");
   end
   if (THR_W < 2) begin : g_bad_thr
      $error("bnn_neuron_unit: THR_W must be at least 2");
   end

   logic [IDX_W-1:0]  rd_idx;
   logic [WORD_W-1:0] rd_word;
   logic [PC_W-1:0]   word_pc;

   bnn_weight_rf #(
      .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)
   ) u_rf (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wt_we), .wr_idx(wt_idx), .wr_data(wt_data),
      .inj_en(inj_en), .inj_idx(inj_idx), .inj_mask(inj_mask),
      .rd_idx(rd_idx), .rd_data(rd_word)
   );

   bnn_xnor_popcnt #(
      .WORD_W(WORD_W), .PC_W(PC_W), .USE_TREE(USE_TREE)
   ) u_pc (
      .act(act_data), .wt(rd_word), .pc(word_pc)
   );

   bnn_seq_ctrl #(
      .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W), .PC_W(PC_W),
      .CNT_W(CNT_W), .THR_W(THR_W), .DIFF_W(DIFF_W)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .start(start), .act_valid(act_valid), .act_ready(act_ready),
      .word_pc(word_pc),
      .cfg_we(cfg_we), .cfg_thr(cfg_thr),
      .word_idx(rd_idx),
      .out_valid(out_valid), .out_act(out_act), .out_popcnt(out_popcnt)
   );
endmodule

// File: tb/sim_bnn_neuron_unit.sv
module sim_bnn_neuron_unit;
   localparam int W = 32;
   localparam int N = 32;
   localparam int IW = 5;
   localparam int CW = 11;
   localparam int TW = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0, act_valid = 1'b0;
   logic [W-1:0] act_data = '0;
   logic act_ready;
   logic wt_we = 1'b0;
   logic [IW-1:0] wt_idx = '0;
   logic [W-1:0] wt_data = '0;
   logic inj_en = 1'b0;
   logic [IW-1:0] inj_idx = '0;
   logic [W-1:0] inj_mask = '0;
   logic cfg_we = 1'b0;
   logic [TW-1:0] cfg_thr = '0;
   logic out_valid, out_act;
   logic [CW-1:0] out_popcnt;

   int checks = 0;
   int errors = 0;
   logic [W-1:0] w_sh [N];
   logic [W-1:0] a_buf [N];
   int thr_sh = 0;
   int got_pc, got_act;

   always #5 clk = ~clk;

   bnn_neuron_unit u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .act_valid(act_valid),
      .act_data(act_data), .act_ready(act_ready), .wt_we(wt_we), .wt_idx(wt_idx),
      .wt_data(wt_data), .inj_en(inj_en), .inj_idx(inj_idx), .inj_mask(inj_mask),
      .cfg_we(cfg_we), .cfg_thr(cfg_thr), .out_valid(out_valid), .out_act(out_act),
      .out_popcnt(out_popcnt)
   );

   task automatic check(input string req, input int got, input int exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   function automatic logic [W-1:0] mix(input int s, input int i);
      return (W'(s) * 32'h9E3779B9) ^ (W'(i) * 32'h85EBCA6B) ^ (W'(i + s) << 7);
   endfunction

   function automatic int model_pc();
      int t = 0;
      for (int k = 0; k < N; k++) t += $countones(~(w_sh[k] ^ a_buf[k]));
      return t;
   endfunction

   function automatic int model_act(input int pc);
      return (pc - thr_sh >= 0) ? 1 : 0;
   endfunction

   task automatic load_weights(input int s);
      for (int k = 0; k < N; k++) begin
         @(negedge clk);
         wt_we = 1'b1; wt_idx = IW'(k); wt_data = mix(s, k); w_sh[k] = mix(s, k);
      end
      @(negedge clk); wt_we = 1'b0;
   endtask

   task automatic set_thr(input int v);
      @(negedge clk);
      cfg_we = 1'b1; cfg_thr = TW'(v); thr_sh = v;
      @(negedge clk); cfg_we = 1'b0;
   endtask

   task automatic fill_acts(input int s);
      for (int k = 0; k < N; k++) a_buf[k] = mix(s + 101, k);
   endtask

   // mode 0 plain, 1 start pulse mid-run, 2 threshold write mid-run
   task automatic run_inf(input int mode, input int mid_thr);
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      for (int k = 0; k < N; k++) begin
         act_valid = 1'b1; act_data = a_buf[k];
         if (k == 5 && mode == 1) start = 1'b1;
         if (k == 5 && mode == 2) begin cfg_we = 1'b1; cfg_thr = TW'(mid_thr); end
         if (k == 3) check("R5 ready during run", int'(act_ready), 1);
         @(negedge clk);
         start = 1'b0; cfg_we = 1'b0;
      end
      act_valid = 1'b0;
      check("R5 out_valid after last word", int'(out_valid), 1);
      check("R5 ready low with result", int'(act_ready), 0);
      got_pc = int'(out_popcnt); got_act = int'(out_act);
      @(negedge clk);
      check("R5 out_valid single cycle", int'(out_valid), 0);
   endtask

   task automatic t_reset();
      check("R1 out_valid reset", int'(out_valid), 0);
      check("R1 act_ready reset", int'(act_ready), 0);
      for (int k = 0; k < N; k++) begin a_buf[k] = '0; w_sh[k] = '0; end
      run_inf(0, 0);
      check("R1 reset weights/threshold count", got_pc, N * W);
      check("R1 reset output", got_act, 1);
   endtask

   task automatic t_basic();
      load_weights(7); fill_acts(7); set_thr(512);
      run_inf(0, 0);
      check("R3 count pattern A", got_pc, model_pc());
      check("R4 sign pattern A", got_act, model_act(model_pc()));
      // R2: all weights +1 against inputs with exactly one -1 per word
      for (int k = 0; k < N; k++) begin a_buf[k] = ~(W'(1) << (k % W)); end
      for (int k = 0; k < N; k++) begin
         @(negedge clk); wt_we = 1'b1; wt_idx = IW'(k); wt_data = '1; w_sh[k] = '1;
      end
      @(negedge clk); wt_we = 1'b0;
      run_inf(0, 0);
      check("R2 xnor mismatch counts zero", got_pc, N * (W - 1));
      // R3 pairing order: only word 9 matches fully, the rest are inverted
      for (int k = 0; k < N; k++) a_buf[k] = (k == 9) ? w_sh[k] : ~w_sh[k];
      run_inf(0, 0);
      check("R3 word order pairing", got_pc, W);
   endtask

   task automatic t_threshold();
      int pc;
      load_weights(21); fill_acts(33); pc = model_pc();
      set_thr(pc);
      run_inf(0, 0);
      check("R4 zero difference fires", got_act, 1);
      set_thr(pc + 1);
      run_inf(0, 0);
      check("R4 negative difference", got_act, 0);
      set_thr(-2048);
      run_inf(0, 0);
      check("R4 most negative threshold", got_act, 1);
      set_thr(2047);
      run_inf(0, 0);
      check("R4 largest threshold", got_act, 0);
   endtask

   task automatic t_start_busy();
      load_weights(44); fill_acts(45); set_thr(500);
      run_inf(1, 0);
      check("R6 start mid-run count", got_pc, model_pc());
      check("R6 start mid-run sign", got_act, model_act(model_pc()));
      run_inf(0, 0);
      check("R10 repeat run count", got_pc, model_pc());
   endtask

   task automatic t_cfg_busy();
      int pc;
      load_weights(60); fill_acts(61); pc = model_pc();
      set_thr(pc);
      run_inf(2, 2047);
      check("R7 thr write mid-run ignored", got_act, 1);
      run_inf(0, 0);
      check("R7 thr write not applied later", got_act, 1);
   endtask

   task automatic t_inject();
      load_weights(80); fill_acts(81); set_thr(0);
      @(negedge clk);
      inj_en = 1'b1; inj_idx = 5'd3; inj_mask = 32'h0000_F0F1;
      w_sh[3] = w_sh[3] ^ 32'h0000_F0F1;
      @(negedge clk); inj_en = 1'b0;
      run_inf(0, 0);
      check("R8 injected weights used", got_pc, model_pc());
      run_inf(0, 0);
      check("R8 injection persists", got_pc, model_pc());
      // R11: write and inject the same word together
      @(negedge clk);
      wt_we = 1'b1; wt_idx = 5'd12; wt_data = 32'hA5A5_0000;
      inj_en = 1'b1; inj_idx = 5'd12; inj_mask = 32'h00FF_00FF;
      w_sh[12] = 32'hA5A5_0000 ^ 32'h00FF_00FF;
      @(negedge clk); wt_we = 1'b0; inj_en = 1'b0;
      for (int k = 0; k < N; k++) a_buf[k] = (k == 12) ? '0 : ~w_sh[k];
      run_inf(0, 0);
      check("R11 write plus inject", got_pc, W - $countones(w_sh[12]));
   endtask

   task automatic t_idle_valid();
      load_weights(90); fill_acts(91); set_thr(300);
      for (int c = 0; c < 3; c++) begin
         @(negedge clk); act_valid = 1'b1; act_data = '1;
         check("R9 idle ready low", int'(act_ready), 0);
      end
      @(negedge clk); act_valid = 1'b0;
      check("R9 no result from idle words", int'(out_valid), 0);
      run_inf(0, 0);
      check("R9 idle words not counted", got_pc, model_pc());
   endtask

   initial begin
      #(200000 * 10);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_threshold();
      t_start_busy();
      t_cfg_busy();
      t_inject();
      t_idle_valid();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule